// File: doc/BRIEF.md
# Soft Reset Register Bank

This block is a small bank of word-wide control registers whose bits drive individual active-high reset lines for peripherals. Software writes a register to hold a peripheral in reset and writes it again to let the peripheral go. Each register bit drives one output line directly from a flop. A line is high exactly while its bit holds 1.

The parameter `MASKED_MODE` selects one of two write schemes at build time. With masked writes, a register carries 16 controls. The upper half of each written word acts as a per-bit enable for the lower half, so one write can set or clear chosen lines and leave every other line as it was. Independent software agents therefore need no shared lock. With plain writes, a register carries 32 controls and a write replaces the whole word. Changing a single line then takes a read, a bit change and a write back.

The bus is a simple synchronous register port with a byte address, write data, a write strobe, a read strobe and registered read data. Registers sit on 4-byte strides. Address bits [1:0] are not decoded. Accesses above the last register are dropped.

Top module: `soft_reset_bank`

## Requirements
- R1: On the synchronous hardware reset, every register takes its preset value: bit i of register k is loaded from `PRESET[32*k+i]`, and the default preset is all zero. The read data also clears to zero.
- R2: In masked mode each register holds 16 controls. Register k is at byte address 4*k, and output line n is bit n%16 of register n/16.
- R3: In masked mode, a write with bit 16+i set asserts line i of the addressed register when bit i is 1, and releases it when bit i is 0.
- R4: In masked mode, a lower bit i whose enable bit 16+i is 0 keeps its previous value on a write.
- R5: In masked mode, a read returns the 16 control bits in data bits [15:0] and zeros in bits [31:16].
- R6: In plain mode each register holds 32 controls, and line n is bit n%32 of register n/32. A write stores all 32 data bits in the addressed register.
- R7: In plain mode, a read returns the stored 32-bit word, so a read, a change of one bit and a write back alter only that line.
- R8: A write whose register index (address bits [ADDR_W-1:2]) is at or above `NUM_REGS` changes no register and no line.
- R9: A read whose register index is at or above `NUM_REGS` returns zero.
- R10: A register and its lines change on the rising edge at which the write strobe is high. Read data appears after the rising edge at which the read strobe is high and holds until the next read.
- R11: While the write strobe is low, the address and write data have no effect on any line.
- R12: Address bits [1:0] are ignored, so byte address 4*k+2 reaches register k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address; bits [ADDR_W-1:2] select the register |
| bus_wdata | input | 32 | Write data (in masked mode the upper half is the bit enable) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| rst_lines | output | NUM_REGS*PER_REG | Reset lines, high while held in reset |

## Verification
Each register bit drives one port line directly. A wrong register state therefore shows on `rst_lines` in the cycle after the write that caused it. No read is needed to see it.

A faulty merge of enable and data, such as an inverted enable or a swapped half, shows as lines that flip when they should hold. It also shows as unaddressed registers that move. A faulty decode shows as a write landing in the wrong slice of lines, or as an out-of-range write that changes lines. A readback fault shows on `bus_rdata` one cycle after the read strobe, as nonzero upper bits or nonzero data for an out-of-range index.

// File: rtl/srb_pkg.sv
package srb_pkg;

  typedef logic [31:0] srb_word_t;

  // Controls carried by one register for the selected write scheme.
  function automatic int unsigned srb_ctrl_per_reg(input bit masked);
    return masked ? 32'd16 : 32'd32;
  endfunction

  // Masked update: lanes whose enable bit is set take the new data.
  function automatic logic [15:0] srb_masked_merge(input logic [15:0] cur,
                                                   input srb_word_t   word);
    logic [15:0] en;
    logic [15:0] val;
    en  = word[31:16];
    val = word[15:0];
    return (cur & ~en) | (val & en);
  endfunction

endpackage

// File: rtl/srb_addr_decode.sv
module srb_addr_decode #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned ADDR_W   = 6,
  localparam int unsigned IDX_W   = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr,
  output logic [IDX_W-1:0]    idx,
  output logic                in_range,
  output logic [NUM_REGS-1:0] wr_sel
);

  logic unused_byte_lane;
  assign unused_byte_lane = ^addr[1:0];

  assign idx      = addr[ADDR_W-1:2];
  assign in_range = (32'(idx) < NUM_REGS);

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_sel
    assign wr_sel[k] = wr && in_range && (32'(idx) == k);
  end

endmodule

// File: rtl/srb_reg_slice.sv
module srb_reg_slice
  import srb_pkg::*;
#(
  parameter bit MASKED_MODE = 1'b1,
  localparam int unsigned PER_REG = srb_ctrl_per_reg(MASKED_MODE),
  parameter logic [PER_REG-1:0] PRESET_VAL = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  srb_word_t          wdata,
  output logic [PER_REG-1:0] q
);

  logic [PER_REG-1:0] q_next;

  if (MASKED_MODE) begin : g_masked
    assign q_next = srb_masked_merge(q, wdata);
  end else begin : g_plain
    assign q_next = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= PRESET_VAL;
    end else if (we) begin
      q <= q_next;
    end
  end

endmodule

// File: rtl/srb_read_port.sv
module srb_read_port
  import srb_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned PER_REG  = 16,
  parameter int unsigned IDX_W    = 4,
  localparam int unsigned SLOTS   = 1 << IDX_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd,
  input  logic                        in_range,
  input  logic [IDX_W-1:0]            idx,
  input  logic [NUM_REGS*PER_REG-1:0] regs_flat,
  output srb_word_t                   rdata
);

  srb_word_t slot [SLOTS];

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    if (k < NUM_REGS) begin : g_live
      assign slot[k] = 32'(regs_flat[k*PER_REG +: PER_REG]);
    end else begin : g_hole
      assign slot[k] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= in_range ? slot[idx] : '0;
    end
  end

endmodule

// File: rtl/soft_reset_bank.sv
module soft_reset_bank
  import srb_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 4,
  parameter bit          MASKED_MODE = 1'b1,
  parameter int unsigned ADDR_W      = 6,
  parameter logic [NUM_REGS*32-1:0] PRESET = '0,
  localparam int unsigned PER_REG    = srb_ctrl_per_reg(MASKED_MODE),
  localparam int unsigned NUM_LINES  = NUM_REGS * PER_REG
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  output logic [31:0]          bus_rdata,
  output logic [NUM_LINES-1:0] rst_lines
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]    idx;
  logic                in_range;
  logic [NUM_REGS-1:0] wr_sel;

  srb_addr_decode #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W)
  ) u_decode (
    .addr     (bus_addr),
    .wr       (bus_wr),
    .idx      (idx),
    .in_range (in_range),
    .wr_sel   (wr_sel)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    srb_reg_slice #(
      .MASKED_MODE (MASKED_MODE),
      .PRESET_VAL  (PRESET[k*32 +: PER_REG])
    ) u_slice (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_sel[k]),
      .wdata (bus_wdata),
      .q     (rst_lines[k*PER_REG +: PER_REG])
    );
  end

  srb_read_port #(
    .NUM_REGS (NUM_REGS),
    .PER_REG  (PER_REG),
    .IDX_W    (IDX_W)
  ) u_read (
    .clk       (clk),
    .rst       (rst),
    .rd        (bus_rd),
    .in_range  (in_range),
    .idx       (idx),
    .regs_flat (rst_lines),
    .rdata     (bus_rdata)
  );

endmodule

// File: rtl/srb_checker.sv
module srb_checker #(
  parameter int unsigned NUM_REGS    = 4,
  parameter bit          MASKED_MODE = 1'b1,
  parameter int unsigned ADDR_W      = 6,
  localparam int unsigned PER_REG    = MASKED_MODE ? 16 : 32,
  localparam int unsigned NUM_LINES  = NUM_REGS * PER_REG
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_wdata,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic [31:0]          bus_rdata,
  input logic [NUM_LINES-1:0] rst_lines
);

  logic [ADDR_W-3:0] c_idx;
  logic              c_ok;
  assign c_idx = bus_addr[ADDR_W-1:2];
  assign c_ok  = (32'(c_idx) < NUM_REGS);

  function automatic logic [PER_REG-1:0] slice_of(input logic [NUM_LINES-1:0] v,
                                                  input logic [ADDR_W-3:0]    k);
    return v[32'(k)*PER_REG +: PER_REG];
  endfunction

  // R11: no write strobe, no line change
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable(rst_lines));

  // R8: writes past the last register are dropped
  p_oor_write_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !c_ok) |=> $stable(rst_lines));

  // R9: reads past the last register return zero
  p_oor_read_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !c_ok) |=> (bus_rdata == 32'd0));

  // R10: read data holds between reads
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  if (MASKED_MODE) begin : g_masked_chk
    // R5: upper half of masked readback is zero
    p_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
      bus_rd |=> (bus_rdata[31:16] == 16'd0));

    // R3, R4: enabled lanes take data, disabled lanes hold
    p_masked_update_r4: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && c_ok) |=>
        (slice_of(rst_lines, $past(c_idx)) ==
         ((slice_of($past(rst_lines), $past(c_idx)) & ~$past(bus_wdata[31:16])) |
          ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16])))));
  end else begin : g_plain_chk
    // R6: plain write stores the whole word
    p_plain_store_r6: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && c_ok) |=> (slice_of(rst_lines, $past(c_idx)) == $past(bus_wdata)));
  end

endmodule

bind soft_reset_bank srb_checker #(
  .NUM_REGS    (NUM_REGS),
  .MASKED_MODE (MASKED_MODE),
  .ADDR_W      (ADDR_W)
) u_srb_checker (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .rst_lines (rst_lines)
);

// File: tb/soft_reset_bank_bench.sv
module soft_reset_bank_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;  // 125 MHz

  // masked instance: 4 registers x 16 lines
  logic [5:0]  m_addr = '0;
  logic [31:0] m_wdata = '0;
  logic        m_wr = 1'b0, m_rd = 1'b0;
  logic [31:0] m_rdata;
  logic [63:0] m_lines;

  // plain instance: 2 registers x 32 lines, preset
  localparam logic [63:0] P_PRESET = 64'h0000_0000_8000_0001;
  logic [5:0]  p_addr = '0;
  logic [31:0] p_wdata = '0;
  logic        p_wr = 1'b0, p_rd = 1'b0;
  logic [31:0] p_rdata;
  logic [63:0] p_lines;

  soft_reset_bank #(.NUM_REGS(4), .MASKED_MODE(1'b1), .ADDR_W(6)) u_soft_reset_bank (
    .clk(clk), .rst(rst), .bus_addr(m_addr), .bus_wdata(m_wdata),
    .bus_wr(m_wr), .bus_rd(m_rd), .bus_rdata(m_rdata), .rst_lines(m_lines));

  soft_reset_bank #(.NUM_REGS(2), .MASKED_MODE(1'b0), .ADDR_W(6), .PRESET(P_PRESET)) u_plain (
    .clk(clk), .rst(rst), .bus_addr(p_addr), .bus_wdata(p_wdata),
    .bus_wr(p_wr), .bus_rd(p_rd), .bus_rdata(p_rdata), .rst_lines(p_lines));

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic m_write(input logic [5:0] a, input logic [31:0] d);
    m_addr = a; m_wdata = d; m_wr = 1'b1;
    @(negedge clk);
    m_wr = 1'b0;
  endtask

  task automatic m_read(input logic [5:0] a);
    m_addr = a; m_rd = 1'b1;
    @(negedge clk);
    m_rd = 1'b0;
  endtask

  task automatic p_write(input logic [5:0] a, input logic [31:0] d);
    p_addr = a; p_wdata = d; p_wr = 1'b1;
    @(negedge clk);
    p_wr = 1'b0;
  endtask

  task automatic p_read(input logic [5:0] a);
    p_addr = a; p_rd = 1'b1;
    @(negedge clk);
    p_rd = 1'b0;
  endtask

  typedef struct packed {
    logic [5:0]  addr;
    logic [31:0] wdata;
    logic [63:0] lines;
    logic [31:0] rdata;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{6'h00, 32'h0001_0001, 64'h0000_0000_0000_0001, 32'h0000_0001}, // R3 assert reg0 bit0
    '{6'h04, 32'hFFFF_00FF, 64'h0000_0000_00FF_0001, 32'h0000_00FF}, // R3 set/clear reg1
    '{6'h04, 32'h000F_0000, 64'h0000_0000_00F0_0001, 32'h0000_00F0}, // R3 release bits 0-3
    '{6'h0C, 32'h8000_8000, 64'h8000_0000_00F0_0001, 32'h0000_8000}, // R2 top line 63
    '{6'h08, 32'h0000_FFFF, 64'h8000_0000_00F0_0001, 32'h0000_0000}, // R4 no enables
    '{6'h00, 32'h0001_0000, 64'h8000_0000_00F0_0000, 32'h0000_0000}, // R3 release line 0
    '{6'h10, 32'hFFFF_FFFF, 64'h8000_0000_00F0_0000, 32'h0000_0000}, // R8/R9 index 4
    '{6'h3C, 32'hFFFF_FFFF, 64'h8000_0000_00F0_0000, 32'h0000_0000}, // R8/R9 index 15
    '{6'h08, 32'hA5A5_FFFF, 64'h8000_A5A5_00F0_0000, 32'h0000_A5A5}, // R4 partial enables
    '{6'h0A, 32'h0005_0000, 64'h8000_A5A0_00F0_0000, 32'h0000_A5A0}  // R12 unaligned addr
  };

  initial begin
    logic [31:0] tmp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 masked lines", m_lines, 64'd0);
    chk("R1 masked rdata", {32'd0, m_rdata}, 64'd0);
    chk("R1 plain preset", p_lines, P_PRESET);

    for (int i = 0; i < NV; i++) begin
      m_write(VEC[i].addr, VEC[i].wdata);
      chk($sformatf("R3/R4 vec%0d lines", i), m_lines, VEC[i].lines);
      m_read(VEC[i].addr);
      chk($sformatf("R5/R9 vec%0d rdata", i), {32'd0, m_rdata}, {32'd0, VEC[i].rdata});
    end

    // R2: line 16*3+15 driven by reg3 bit15
    chk("R2 line63", {63'd0, m_lines[63]}, 64'd1);

    // R10: no change before the edge, change right after it
    m_addr = 6'h00; m_wdata = 32'h0002_0002; m_wr = 1'b1;
    #1;
    chk("R10 before edge", m_lines, 64'h8000_A5A0_00F0_0000);
    @(negedge clk);
    m_wr = 1'b0;
    chk("R10 after edge", m_lines, 64'h8000_A5A0_00F0_0002);

    // R11: data and address without strobe
    m_addr = 6'h04; m_wdata = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk);
    chk("R11 idle bus", m_lines, 64'h8000_A5A0_00F0_0002);

    // R10: read data holds without read strobe
    m_read(6'h08);
    m_addr = 6'h00;
    repeat (2) @(negedge clk);
    chk("R10 rdata hold", {32'd0, m_rdata}, 64'h0000_A5A0);

    // R6: plain whole-word write
    p_write(6'h04, 32'hDEAD_BEEF);
    chk("R6 plain store", p_lines, 64'hDEAD_BEEF_8000_0001);
    // R7: readback and read-modify-write
    p_read(6'h04);
    chk("R7 plain read", {32'd0, p_rdata}, 64'h0000_0000_DEAD_BEEF);
    p_read(6'h00);
    tmp = p_rdata | 32'h0000_0010;
    p_write(6'h00, tmp);
    chk("R7 plain rmw", p_lines, 64'hDEAD_BEEF_8000_0011);
    // R8/R9 plain out of range
    p_write(6'h08, 32'h1234_5678);
    chk("R8 plain oor write", p_lines, 64'hDEAD_BEEF_8000_0011);
    p_read(6'h08);
    chk("R9 plain oor read", {32'd0, p_rdata}, 64'd0);

    // R1: reset again restores preset
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 masked rereset", m_lines, 64'd0);
    chk("R1 plain rereset", p_lines, P_PRESET);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule